// File: doc/BRIEF.md
# Converter Power-State Controller

This block follows the power state of a serially clocked analog-to-digital converter and tells the analog front end which parts may be switched off. It runs on a fast system clock and samples the serial clock, chip select and frame sync as ordinary synchronous inputs. It detects falling serial-clock edges and counts them from the start of each conversion cycle. A cycle holds sixteen serial clocks. Two mechanisms can lower power. The first is an automatic idle power-down, entered when the host stops framing or stops clocking. The second is a commanded software power-down, taken from a configuration bit.

The host is of one of two kinds. A DSP-style host pulses frame sync, and a cycle starts on a falling serial-clock edge that sees frame sync low. A microcontroller-style host holds frame sync high, and a cycle starts every sixteen serial clocks. The entry and exit rules of the idle power-down differ between the two kinds. The software power-down bit is only looked at on a cycle start. Leaving that state costs sixteen serial clocks of recovery. The ready flag stays low during any recovery.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While reset is held, or while `csN` is high, `compOn`, `clkBufOn`, `refOn` and `ready` are all 0. A high-to-low `csN` starts a recovery with `compOn`, `clkBufOn` and `refOn` at 1 and `ready` at 0. `ready` rises on the 16th falling `sclk` edge after that.
- R2: With `dspMode`=1 and `autoPdEn`=1, a falling `sclk` edge with `fsync` low starts a cycle and counts as edge 1. If the 17th falling edge of a cycle sees `fsync` high, the block enters idle power-down: `compOn`=0, `clkBufOn`=0, `refOn`=1, `ready`=0. If that edge sees `fsync` low instead, a new cycle starts and the block stays active.
- R3: In idle power-down with `dspMode`=1, a rising `fsync` starts a one-clock recovery (outputs 1,1,1,0). The next falling `sclk` edge makes the block ready.
- R4: With `dspMode`=0 and `autoPdEn`=1, cycles are counted as runs of 16 falling edges. Once edge 16 of a cycle has occurred and `IDLE_TICKS` system clocks pass with no further falling edge, the block enters idle power-down.
- R5: In idle power-down with `dspMode`=0, the next falling `sclk` edge starts a one-clock recovery. The falling edge after that makes the block ready.
- R6: With `autoPdEn`=0, neither a missed frame nor a stopped serial clock changes the outputs from the active state.
- R7: `swPdBit` is sampled only on a cycle start. A change in the middle of a cycle has no effect until the next cycle start. A cycle start that sees `swPdBit`=1 enters software power-down with all four outputs 0.
- R8: In software power-down, a cycle start that sees `swPdBit`=0 begins a recovery (outputs 1,1,1,0) that lasts 16 falling `sclk` edges, counting that cycle start as the load point. `ready` is still 0 after 15 further edges and is 1 after the 16th.
- R9: Software power-down takes precedence. While in it, missed frames or a stopped clock never turn `refOn` back on. A cycle start with `swPdBit`=1 during a one-clock recovery from idle power-down goes straight to software power-down.
- R10: Power state is not retained across a deselect. After `csN` has been high, the block always needs the full 16-edge recovery, even if it was active before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, sampled; its falling edges are counted |
| csN | input | 1 | Active-low chip select |
| fsync | input | 1 | Frame sync from the host |
| dspMode | input | 1 | 1 = host pulses frame sync, 0 = host holds frame sync high |
| swPdBit | input | 1 | Decoded software power-down request bit |
| autoPdEn | input | 1 | Decoded idle power-down enable (1 = enabled) |
| compOn | output | 1 | Comparator may be powered |
| clkBufOn | output | 1 | Clock buffer may be powered |
| refOn | output | 1 | Reference may be powered |
| ready | output | 1 | Converter powered and fully recovered |

## Verification
The bench counts recovery edges exactly: it checks that `ready` is still low after 15 edges and high after the 16th. A counter that is off by one would release `ready` an edge early or late. It drives a 17th edge with frame sync low and then with frame sync high, so a design that powers down on edge 16, or that ignores a new frame, is caught. It flips the software bit in the middle of a cycle and back again before the cycle start, which exposes a design that samples the bit at any time other than the cycle start. It lets frames lapse and the clock stop while in software power-down, which catches a design that lets the idle rule switch the reference back on.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_ACTIVE,
    PS_AUTO,
    PS_SOFT,
    PS_WAKE
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic loadRec;
    logic recLong;
  } pdStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic fallEdge;
    logic cycleStart;
    logic missFrame;
    logic idleExpire;
    logic fsRise;
    logic recDone;
  } pdEvent_t;

endpackage

// File: rtl/pwr_edge_dp.sv
module pwr_edge_dp
  import pmc_pkg::*;
#(
  parameter int CYCLE_CLKS = 16,
  parameter int REC_LONG   = 16,
  parameter int REC_SHORT  = 1,
  parameter int IDLE_TICKS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      fsync,
  input  logic      dspMode,
  input  pdStrobe_t strb,
  output pdEvent_t  ev
);

  localparam int CNT_W  = $clog2(CYCLE_CLKS + 1);
  localparam int REC_W  = $clog2(REC_LONG + 1);
  localparam int IDLE_W = $clog2(IDLE_TICKS + 1);

  logic              prevSclk;
  logic              prevFs;
  logic [CNT_W-1:0]  edgeCnt;
  logic [REC_W-1:0]  recCnt;
  logic [IDLE_W-1:0] idleCnt;

  logic fallEdge;
  logic cntFull;
  logic cntZero;
  logic cycleStart;

  assign fallEdge   = prevSclk & ~sclk;
  assign cntFull    = (edgeCnt == CNT_W'(CYCLE_CLKS));
  assign cntZero    = (edgeCnt == '0);
  assign cycleStart = fallEdge & (dspMode ? ~fsync : (cntFull | cntZero));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSclk <= 1'b0;
      prevFs   <= 1'b1;
    end else begin
      prevSclk <= sclk;
      prevFs   <= fsync;
    end
  end

  // edge counter within a conversion cycle
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCnt) begin
      edgeCnt <= '0;
    end else if (fallEdge) begin
      if (cycleStart)   edgeCnt <= CNT_W'(1);
      else if (!cntFull) edgeCnt <= edgeCnt + CNT_W'(1);
    end
  end

  // system clocks since the last serial clock fall
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCnt || fallEdge) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_W'(IDLE_TICKS)) begin
      idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  // recovery edge counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      recCnt <= '0;
    end else if (strb.loadRec) begin
      recCnt <= strb.recLong ? REC_W'(REC_LONG) : REC_W'(REC_SHORT);
    end else if (fallEdge && recCnt != '0) begin
      recCnt <= recCnt - REC_W'(1);
    end
  end

  always_comb begin
    ev.fallEdge   = fallEdge;
    ev.cycleStart = cycleStart;
    ev.missFrame  = dspMode & fallEdge & fsync & cntFull;
    ev.idleExpire = ~dspMode & cntFull & (idleCnt == IDLE_W'(IDLE_TICKS));
    ev.fsRise     = dspMode & fsync & ~prevFs;
    ev.recDone    = fallEdge & (recCnt == REC_W'(1));
  end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      dspMode,
  input  logic      swPdBit,
  input  logic      autoPdEn,
  input  pdEvent_t  ev,
  output pdStrobe_t strb,
  output logic      compOn,
  output logic      clkBufOn,
  output logic      refOn,
  output logic      ready
);

  pwrState_t state;
  pwrState_t stateNxt;

  always_comb begin
    stateNxt     = state;
    strb.clrCnt  = csN || (state == PS_OFF);
    strb.loadRec = 1'b0;
    strb.recLong = 1'b0;
    if (csN) begin
      stateNxt = PS_OFF;
    end else if (state != PS_OFF && ev.cycleStart && swPdBit) begin
      stateNxt = PS_SOFT;
    end else begin
      unique case (state)
        PS_OFF: begin
          stateNxt     = PS_WAKE;
          strb.loadRec = 1'b1;
          strb.recLong = 1'b1;
        end
        PS_ACTIVE: begin
          if (autoPdEn && (dspMode ? ev.missFrame : ev.idleExpire))
            stateNxt = PS_AUTO;
        end
        PS_AUTO: begin
          if (dspMode ? ev.fsRise : ev.fallEdge) begin
            stateNxt     = PS_WAKE;
            strb.loadRec = 1'b1;
          end
        end
        PS_SOFT: begin
          if (ev.cycleStart) begin
            stateNxt     = PS_WAKE;
            strb.loadRec = 1'b1;
            strb.recLong = 1'b1;
          end
        end
        PS_WAKE: begin
          if (ev.recDone) stateNxt = PS_ACTIVE;
        end
        default: stateNxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_OFF;
    else       state <= stateNxt;
  end

  always_comb begin
    compOn   = (state == PS_ACTIVE) || (state == PS_WAKE);
    clkBufOn = compOn;
    refOn    = compOn || (state == PS_AUTO);
    ready    = (state == PS_ACTIVE);
  end

  // R1
  cs_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !ready);

  // R8
  ready_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(ev.fallEdge));

  // R9
  ref_off_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refOn) |-> ($past(csN) || $past(swPdBit)));

  // R6
  idle_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(compOn) && refOn) |-> $past(autoPdEn));

endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import pmc_pkg::*;
#(
  parameter int CYCLE_CLKS = 16,
  parameter int REC_LONG   = 16,
  parameter int REC_SHORT  = 1,
  parameter int IDLE_TICKS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic fsync,
  input  logic dspMode,
  input  logic swPdBit,
  input  logic autoPdEn,
  output logic compOn,
  output logic clkBufOn,
  output logic refOn,
  output logic ready
);

  pdStrobe_t strb;
  pdEvent_t  ev;

  pwr_edge_dp #(
    .CYCLE_CLKS(CYCLE_CLKS),
    .REC_LONG  (REC_LONG),
    .REC_SHORT (REC_SHORT),
    .IDLE_TICKS(IDLE_TICKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .fsync  (fsync),
    .dspMode(dspMode),
    .strb   (strb),
    .ev     (ev)
  );

  pwr_state_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .dspMode (dspMode),
    .swPdBit (swPdBit),
    .autoPdEn(autoPdEn),
    .ev      (ev),
    .strb    (strb),
    .compOn  (compOn),
    .clkBufOn(clkBufOn),
    .refOn   (refOn),
    .ready   (ready)
  );

endmodule

// File: tb/adc_pwr_ctrl_bench.sv
module adc_pwr_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  // expected output codes {compOn, clkBufOn, refOn, ready}
  localparam logic [3:0] ST_ACT  = 4'b1111;
  localparam logic [3:0] ST_WAKE = 4'b1110;
  localparam logic [3:0] ST_IDLE = 4'b0010;
  localparam logic [3:0] ST_DOWN = 4'b0000;

  logic clk = 1'b0;
  logic rstN, sclk, csN, fsync, dspMode, swPdBit, autoPdEn;
  logic compOn, clkBufOn, refOn, ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      req;
    logic [3:0] exp;
  } sbItem_t;

  sbItem_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pwr_ctrl u_adc_pwr_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .fsync(fsync),
    .dspMode(dspMode), .swPdBit(swPdBit), .autoPdEn(autoPdEn),
    .compOn(compOn), .clkBufOn(clkBufOn), .refOn(refOn), .ready(ready)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      sbItem_t it;
      wait (sbQ.size() > 0);
      it = sbQ.pop_front();
      checks++;
      if ({compOn, clkBufOn, refOn, ready} !== it.exp) begin
        errors++;
        $display("FAIL %s: got %b expected %b", it.req,
                 {compOn, clkBufOn, refOn, ready}, it.exp);
      end
    end
  end

  // driver side
  task automatic expectOut(input string req, input logic [3:0] e);
    sbItem_t it;
    it.req = req;
    it.exp = e;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  task automatic sclkFall(input logic fsVal);
    @(negedge clk);
    fsync = fsVal;
    sclk  = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic falls(input int n, input logic fsVal);
    for (int i = 0; i < n; i++) sclkFall(fsVal);
  endtask

  task automatic wakeLong(input logic fsVal, input string req);
    falls(15, fsVal);
    expectOut(req, ST_WAKE);
    sclkFall(fsVal);
    expectOut(req, ST_ACT);
  endtask

  task automatic fsPulseRise();
    @(negedge clk);
    fsync = 1'b0;
    repeat (2) @(negedge clk);
    fsync = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; csN = 1; sclk = 0; fsync = 1; dspMode = 1;
    swPdBit = 0; autoPdEn = 1;
    repeat (3) @(negedge clk);
    expectOut("R1", ST_DOWN);
    rstN = 1;
    repeat (2) @(negedge clk);
    expectOut("R1", ST_DOWN);
    csN = 0;
    repeat (2) @(negedge clk);
    expectOut("R1", ST_WAKE);
    wakeLong(1'b0, "R1");

    // DSP host: framing and idle power-down
    sclkFall(1'b0);
    falls(15, 1'b1);
    expectOut("R2", ST_ACT);
    sclkFall(1'b0);            // 17th edge with frame: new cycle
    expectOut("R2", ST_ACT);
    falls(15, 1'b1);
    sclkFall(1'b1);            // 17th edge, no frame
    expectOut("R2", ST_IDLE);
    fsPulseRise();
    expectOut("R3", ST_WAKE);
    sclkFall(1'b0);
    expectOut("R3", ST_ACT);

    // R6 in DSP mode
    autoPdEn = 0;
    falls(16, 1'b1);
    expectOut("R6", ST_ACT);
    autoPdEn = 1;
    sclkFall(1'b0);

    // R7 in DSP mode: mid-cycle changes
    swPdBit = 1;
    falls(5, 1'b1);
    expectOut("R7", ST_ACT);
    swPdBit = 0;
    sclkFall(1'b0);
    expectOut("R7", ST_ACT);
    swPdBit = 1;
    sclkFall(1'b0);
    expectOut("R7", ST_DOWN);

    // R9: lapsed frames keep everything off
    falls(20, 1'b1);
    expectOut("R9", ST_DOWN);
    swPdBit = 0;
    sclkFall(1'b0);
    expectOut("R8", ST_WAKE);
    wakeLong(1'b0, "R8");

    // R9: soft request during short recovery
    falls(15, 1'b1);
    sclkFall(1'b1);
    expectOut("R2", ST_IDLE);
    fsPulseRise();
    expectOut("R3", ST_WAKE);
    swPdBit = 1;
    sclkFall(1'b0);
    expectOut("R9", ST_DOWN);
    swPdBit = 0;
    sclkFall(1'b0);
    expectOut("R8", ST_WAKE);
    wakeLong(1'b0, "R8");

    // microcontroller host
    @(negedge clk);
    dspMode = 0;
    fsync = 1;
    falls(15, 1'b1);
    expectOut("R4", ST_ACT);
    repeat (12) @(negedge clk);
    expectOut("R4", ST_IDLE);
    sclkFall(1'b1);
    expectOut("R5", ST_WAKE);
    sclkFall(1'b1);
    expectOut("R5", ST_ACT);

    autoPdEn = 0;
    falls(14, 1'b1);
    repeat (12) @(negedge clk);
    expectOut("R6", ST_ACT);
    sclkFall(1'b1);
    autoPdEn = 1;

    swPdBit = 1;
    falls(15, 1'b1);
    expectOut("R7", ST_ACT);
    sclkFall(1'b1);
    expectOut("R7", ST_DOWN);

    falls(15, 1'b1);
    repeat (12) @(negedge clk);
    expectOut("R9", ST_DOWN);
    swPdBit = 0;
    sclkFall(1'b1);
    expectOut("R8", ST_WAKE);
    wakeLong(1'b1, "R8");

    // R10: deselect drops state
    csN = 1;
    repeat (2) @(negedge clk);
    expectOut("R10", ST_DOWN);
    csN = 0;
    repeat (2) @(negedge clk);
    expectOut("R10", ST_WAKE);
    wakeLong(1'b1, "R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule